// File: doc/BRIEF.md
# Three-Edge Chip-Select Conversion Sequencer

This block is the digital control core of a 14-bit successive-approximation converter that talks to a host over a parallel bus. The host runs each conversion cycle with nothing but chip-select falling edges and the level of a read/convert line. The first accepted edge wakes the converter and starts tracking the input. The next edge freezes the sample and starts the bit trials. A further edge, with read/convert high, puts the result on the bus. The read/convert level at the conversion edge also chooses what happens after the conversion. The reference can stay powered (standby), or it can be switched off (shutdown).

The analog comparator is modelled by a 14-bit input word, which is captured at the conversion edge and resolved MSB first by the trial loop. An active-low end-of-conversion flag tells the host when the result is ready. The bus is presented either at full width or as two bytes chosen by a high-byte select input. The bus drive enable is brought out so that a pad ring can build the three-state driver. Chip-select, read/convert and the reset request are synchronized by two flops before any decision is made.

Top module: `cs3_sar_sequencer`

## Requirements
- R1: From idle, a chip-select falling edge with read/convert low starts acquisition: ref_on goes high and ref_off_flag clears. The same edge with read/convert high is ignored, and ref_on stays as it was.
- R2: In acquisition, the next chip-select falling edge (at either read/convert level) starts a conversion. Chip-select edges during the conversion have no effect.
- R3: A conversion lasts exactly W*TRIAL_CYC clocks (56 by default) and then drives eoc_n low. The result equals the captured input word in straight binary.
- R4: Read/convert low at the conversion edge keeps ref_on high after the conversion. Read/convert high at that edge drops ref_on and sets ref_off_flag when eoc_n falls.
- R5: After eoc_n is low, a falling edge with read/convert high enables the bus with the result. The following chip-select rise disables the bus and returns eoc_n high.
- R6: dbus_oe is low in idle, acquisition and conversion, and dbus reads zero whenever dbus_oe is low.
- R7: With byte_wide high, hbe high presents {2'b00, result[13:8]} on dbus[7:0] and hbe low presents result[7:0]. dbus[13:8] is zero in this mode.
- R8: A reset request seen while chip-select is high returns the block to idle: eoc_n high, bus off, ref_on low, ref_off_flag low. The next falling edge with read/convert low begins acquisition. A request seen while chip-select is low is ignored.
- R9: After eoc_n is low, a falling edge with read/convert low skips the read. It returns eoc_n high and starts a new acquisition with ref_on high.
- R10: The response to a chip-select change appears on the outputs after the third rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_cnv | input | 1 | Read/convert qualifier, asynchronous |
| rst_req | input | 1 | Sequencer reset request, active high, asynchronous |
| hbe | input | 1 | High-byte select for byte-wide mode |
| byte_wide | input | 1 | Strap: 1 selects the byte-wide bus |
| sample_in | input | W | Digital stand-in for the comparator input |
| eoc_n | output | 1 | End of conversion, low when a result is ready |
| ref_on | output | 1 | Reference and buffer power enable |
| ref_off_flag | output | 1 | Set by a shutdown conversion, cleared at acquisition |
| dbus_oe | output | 1 | Data bus drive enable |
| dbus | output | W | Data bus value, zero when not driven |

## Verification
The assertions assume that sample_in stays stable while the block samples it, and that chip-select and read/convert change no faster than the synchronizer can follow. The bench meets these assumptions by changing sample_in only well before a conversion edge. It also holds every chip-select level and its read/convert qualifier for four clocks, and it drives all inputs on the falling clock edge. Within that envelope, the stimulus covers both power choices, both bus widths and both byte halves. It also covers edges that arrive during a conversion, a read that is skipped, and reset requests with chip-select at either level.

// File: rtl/cs3_sar_sequencer.sv
module cs3_sar_sequencer #(
  parameter int W         = 14,
  parameter int BYTE      = 8,
  parameter int TRIAL_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_cnv,
  input  logic         rst_req,
  input  logic         hbe,
  input  logic         byte_wide,
  input  logic [W-1:0] sample_in,
  output logic         eoc_n,
  output logic         ref_on,
  output logic         ref_off_flag,
  output logic         dbus_oe,
  output logic [W-1:0] dbus
);
  localparam int BW       = $clog2(W);
  localparam int TW       = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam int CONV_CYC = W * TRIAL_CYC;
  localparam int CW       = $clog2(CONV_CYC + 2);
  localparam int HI_W     = W - BYTE;

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_CONV, S_DONE, S_READ} st_t;

  st_t           state;
  logic [1:0]    cs_sy, rc_sy, rs_sy;
  logic          cs_d;
  logic [W-1:0]  hold, sar;
  logic [BW-1:0] bit_i;
  logic [TW-1:0] tcnt;
  logic          off_sel;

  wire cs_s    = cs_sy[1];
  wire rc_s    = rc_sy[1];
  wire rs_s    = rs_sy[1];
  wire cs_fall = cs_d & ~cs_s;
  wire cs_rise = ~cs_d & cs_s;

  wire [W-1:0] mask  = W'(1) << bit_i;
  wire [W-1:0] cand  = sar | mask;
  wire         keep  = hold >= cand;
  wire         tstep = tcnt == TW'(TRIAL_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      rc_sy <= 2'b00;
      rs_sy <= 2'b00;
      cs_d  <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      rc_sy <= {rc_sy[0], rd_cnv};
      rs_sy <= {rs_sy[0], rst_req};
      cs_d  <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      eoc_n        <= 1'b1;
      ref_on       <= 1'b0;
      ref_off_flag <= 1'b0;
      dbus_oe      <= 1'b0;
      hold         <= '0;
      sar          <= '0;
      bit_i        <= '0;
      tcnt         <= '0;
      off_sel      <= 1'b0;
    end else if (rs_s && cs_s) begin
      state        <= S_IDLE;
      eoc_n        <= 1'b1;
      ref_on       <= 1'b0;
      ref_off_flag <= 1'b0;
      dbus_oe      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (cs_fall && !rc_s) begin
          state        <= S_ACQ;
          ref_on       <= 1'b1;
          ref_off_flag <= 1'b0;
        end
        S_ACQ: if (cs_fall) begin
          state   <= S_CONV;
          hold    <= sample_in;
          sar     <= '0;
          bit_i   <= BW'(W - 1);
          tcnt    <= '0;
          off_sel <= rc_s;
        end
        S_CONV: begin
          if (tstep) begin
            tcnt <= '0;
            if (keep) sar <= cand;
            if (bit_i == '0) begin
              state <= S_DONE;
              eoc_n <= 1'b0;
              if (off_sel) begin
                ref_on       <= 1'b0;
                ref_off_flag <= 1'b1;
              end
            end else begin
              bit_i <= bit_i - 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_DONE: if (cs_fall) begin
          if (rc_s) begin
            state   <= S_READ;
            dbus_oe <= 1'b1;
          end else begin
            state        <= S_ACQ;
            eoc_n        <= 1'b1;
            ref_on       <= 1'b1;
            ref_off_flag <= 1'b0;
          end
        end
        S_READ: if (cs_rise) begin
          state   <= S_IDLE;
          dbus_oe <= 1'b0;
          eoc_n   <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire [BYTE-1:0] hi_byte = {{(2*BYTE-W){1'b0}}, sar[W-1:BYTE]};
  wire [BYTE-1:0] sel_byte = hbe ? hi_byte : sar[BYTE-1:0];

  assign dbus = !dbus_oe  ? '0 :
                byte_wide ? {{HI_W{1'b0}}, sel_byte} : sar;

  logic [CW-1:0] conv_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               conv_len <= '0;
    else if (state == S_CONV) conv_len <= conv_len + 1'b1;
    else                      conv_len <= '0;
  end

  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> conv_len == CW'(CONV_CYC));
  p_conv_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CONV |-> conv_len < CW'(CONV_CYC));
  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> sar == hold);
  p_flag_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_off_flag |-> !ref_on);
  p_bus_needs_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> !eoc_n);
  p_bus_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbus_oe) |-> $past(cs_fall) && $past(rc_s));
  p_byte_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wide |-> dbus[W-1:BYTE] == '0);
  p_rst_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_s && cs_s) |=> eoc_n && !dbus_oe && !ref_on);
endmodule

// File: tb/cs3_sar_sequencer_tb.sv
`timescale 1ns/1ps
module cs3_sar_sequencer_tb;
  localparam int W = 14;
  localparam int T = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_cnv = 1'b0, rst_req = 1'b0, hbe = 1'b0, byte_wide = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic eoc_n, ref_on, ref_off_flag, dbus_oe;
  logic [W-1:0] dbus;

  always #4 clk = ~clk;

  cs3_sar_sequencer #(.W(W), .BYTE(8), .TRIAL_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv), .rst_req(rst_req),
    .hbe(hbe), .byte_wide(byte_wide), .sample_in(sample_in),
    .eoc_n(eoc_n), .ref_on(ref_on), .ref_off_flag(ref_off_flag),
    .dbus_oe(dbus_oe), .dbus(dbus));

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // behavioural reference: 0 idle, 1 acquire, 2 convert, 3 ready, 4 reading
  int m_st, m_cnt;
  bit m_eoc_n, m_ref, m_flag, m_oe, m_off;
  logic [W-1:0] m_res;
  bit c1, c2, cq, r1, r2, x1, x2;

  always @(posedge clk) begin
    bit fall, rise;
    if (!rst_n) begin
      m_st = 0; m_eoc_n = 1; m_ref = 0; m_flag = 0; m_oe = 0; m_off = 0; m_res = '0; m_cnt = 0;
      c1 = 1; c2 = 1; cq = 1; r1 = 0; r2 = 0; x1 = 0; x2 = 0;
    end else begin
      fall = cq && !c2;
      rise = !cq && c2;
      if (x2 && c2) begin
        m_st = 0; m_eoc_n = 1; m_ref = 0; m_flag = 0; m_oe = 0;
      end else begin
        case (m_st)
          0: if (fall && !r2) begin m_st = 1; m_ref = 1; m_flag = 0; end
          1: if (fall) begin m_st = 2; m_res = sample_in; m_off = r2; m_cnt = W * T; end
          2: begin
            m_cnt--;
            if (m_cnt == 0) begin
              m_st = 3; m_eoc_n = 0;
              if (m_off) begin m_ref = 0; m_flag = 1; end
            end
          end
          3: if (fall) begin
            if (r2) begin m_st = 4; m_oe = 1; end
            else begin m_st = 1; m_eoc_n = 1; m_ref = 1; m_flag = 0; end
          end
          default: if (rise) begin m_st = 0; m_oe = 0; m_eoc_n = 1; end
        endcase
      end
      cq = c2; c2 = c1; c1 = cs_n;
      r2 = r1; r1 = rd_cnv;
      x2 = x1; x1 = rst_req;
    end
  end

  always @(posedge clk) begin
    logic [W-1:0] e;
    #2;
    if (rst_n && !done) begin
      e = !m_oe ? '0 : !byte_wide ? m_res :
          hbe ? {8'h00, 2'b00, m_res[13:8]} : {6'b0, m_res[7:0]};
      chk("R3 eoc_n", W'(eoc_n), W'(m_eoc_n));
      chk("R4 ref_on", W'(ref_on), W'(m_ref));
      chk("R4 ref_off_flag", W'(ref_off_flag), W'(m_flag));
      chk("R6 dbus_oe", W'(dbus_oe), W'(m_oe));
      chk(byte_wide ? "R7 dbus" : "R5 dbus", dbus, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      report();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_edge(input bit rc);
    rd_cnv = rc; cs_n = 1'b0; tick(4);
    cs_n = 1'b1; tick(4);
  endtask

  task automatic convert(input logic [W-1:0] s, input bit off);
    sample_in = s; tick(1);
    cs_edge(off);
    tick(W * T + 4);
  endtask

  initial begin
    tick(3);
    chk("R8 reset eoc_n", W'(eoc_n), W'(1));
    chk("R6 reset dbus_oe", W'(dbus_oe), W'(0));
    chk("R8 reset ref_on", W'(ref_on), W'(0));
    rst_n = 1'b1;
    tick(2);

    cs_edge(1'b1);
    chk("R1 ignored edge ref_on", W'(ref_on), W'(0));

    rd_cnv = 1'b0; cs_n = 1'b0;
    tick(1); chk("R10 one edge", W'(ref_on), W'(0));
    tick(1); chk("R10 two edges", W'(ref_on), W'(0));
    tick(1); chk("R10 three edges", W'(ref_on), W'(1));
    tick(2); cs_n = 1'b1; tick(4);
    chk("R1 acquisition ref_on", W'(ref_on), W'(1));

    convert(14'h2A5C, 1'b0);
    chk("R3 eoc low", W'(eoc_n), W'(0));
    chk("R4 standby ref_on", W'(ref_on), W'(1));
    rd_cnv = 1'b1; cs_n = 1'b0; tick(4);
    #1 chk("R5 full word", dbus, 14'h2A5C);
    hbe = 1'b1; #1 chk("R5 hbe ignored in wide mode", dbus, 14'h2A5C);
    tick(1); hbe = 1'b0;
    cs_n = 1'b1; tick(4);
    chk("R5 bus released", W'(dbus_oe), W'(0));
    chk("R5 eoc high", W'(eoc_n), W'(1));

    cs_edge(1'b0);
    sample_in = 14'h3FFF; tick(1);
    cs_edge(1'b1);
    cs_edge(1'b1);
    cs_edge(1'b0);
    chk("R2 edges ignored during conversion", W'(eoc_n), W'(1));
    chk("R6 no drive while converting", W'(dbus_oe), W'(0));
    tick(44);
    chk("R4 shutdown ref_on", W'(ref_on), W'(0));
    chk("R4 shutdown flag", W'(ref_off_flag), W'(1));
    byte_wide = 1'b1;
    rd_cnv = 1'b1; cs_n = 1'b0; tick(4);
    hbe = 1'b1; #1 chk("R7 high byte", dbus, 14'h003F);
    tick(1); hbe = 1'b0; #1 chk("R7 low byte", dbus, 14'h00FF);
    tick(1); cs_n = 1'b1; tick(4);
    cs_edge(1'b0);
    chk("R1 flag cleared", W'(ref_off_flag), W'(0));

    convert(14'h0001, 1'b0);
    cs_edge(1'b0);
    chk("R9 read skipped eoc", W'(eoc_n), W'(1));
    chk("R9 ref on", W'(ref_on), W'(1));
    convert(14'h2000, 1'b0);
    rd_cnv = 1'b1; cs_n = 1'b0; tick(4);
    hbe = 1'b1; #1 chk("R7 high byte msb", dbus, 14'h0020);
    tick(1); hbe = 1'b0; #1 chk("R7 low byte zero", dbus, 14'h0000);
    tick(1);
    rst_req = 1'b1; tick(4); rst_req = 1'b0; tick(2);
    chk("R8 request with cs low ignored", W'(dbus_oe), W'(1));
    cs_n = 1'b1; tick(4);
    byte_wide = 1'b0;

    cs_edge(1'b0);
    rst_req = 1'b1; tick(4); rst_req = 1'b0; tick(3);
    chk("R8 reset to idle ref_on", W'(ref_on), W'(0));
    cs_edge(1'b0);
    chk("R8 next edge acquires", W'(ref_on), W'(1));
    convert(14'h1555, 1'b0);
    rd_cnv = 1'b1; cs_n = 1'b0; tick(4);
    #1 chk("R3 result word", dbus, 14'h1555);
    tick(1); cs_n = 1'b1; tick(6);

    done = 1;
    report();
  end
endmodule